// File: doc/BRIEF.md
# Flash Block-Protection Removal Controller

This controller takes a serial flash out of software block protection. When started, it reads the flash status register through a request/acknowledge read port. It then decides whether anything needs to be done. If so, it issues status-register writes through a request/acknowledge write port, which feeds the write sequencer. Each write is confirmed by reading the status back.

Four 8-bit masks are captured when the sequence starts:

- **Protection bits:** the bits that must end up clear.
- **Lock bits:** the bits that freeze the rest of the register while set.
- **Hardware-protect bits:** the bits that read zero while the external write-protect pin is held active.
- **Keep bits:** the bits that may survive the final write.

A keep mask of zero clears the whole register. Some chips need this, because they only unlock globally when unrelated bits are also written to zero.

Removal runs in two stages. First the lock bits are dropped, leaving every other bit as read. Then the protection is cleared. The block ends with a one-cycle `done` pulse and a result code that says which step, if any, failed.

Top module: `flash_unprotect_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `sr_rd_req` and `sr_wr_req` are low and `result_code` is 0.
- R2: A `start` pulse while idle captures the four masks and begins with a status read. A `start` pulse while busy has no effect: no further read follows the end of the sequence.
- R3: If the first status read has no protection bit set, the sequence ends with result 0 (success) and issues no write.
- R4: If a lock bit is set, the hardware-protect mask is nonzero and every bit under it reads 0, the sequence ends with result 1 (hardware protect) and issues no write.
- R5: If a lock bit is set and R4 does not apply, the first write carries the status just read with only the lock bits cleared.
- R6: After that lock write the status is read again. If any lock bit is still set, the sequence ends with result 2 (lock stuck) and issues no further write.
- R7: The final write carries the most recently read status with the protection and lock bits cleared, ANDed with the keep mask.
- R8: After the final write the status is read again. The result is 3 (protection stuck) if any protection bit is still set, else 0.
- R9: `sr_wr_fail` during a write request ends the sequence on the next edge with result 4 (write error). No further request follows.
- R10: A read or write request stays high until it is acknowledged (or, for a write, failed). The two requests are never high together, and `done` lasts exactly one cycle.
- R11: A zero hardware-protect mask skips the check of R4, so a set lock bit always leads to the lock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a removal sequence (idle only) |
| prot_mask | input | 8 | Status bits that signal active block protection |
| lock_mask | input | 8 | Status bits that lock the register |
| hwp_mask | input | 8 | Status bits that read 0 while hardware protect is active |
| keep_mask | input | 8 | Bits allowed to survive the final write |
| sr_rd_req | output | 1 | Status read request |
| sr_rd_ack | input | 1 | Read completed, `sr_rd_data` valid |
| sr_rd_data | input | 8 | Status value returned |
| sr_wr_req | output | 1 | Status write request |
| sr_wr_data | output | 8 | Value to write to the status register |
| sr_wr_ack | input | 1 | Write completed |
| sr_wr_fail | input | 1 | Write reported an error |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result_code | output | 3 | 0 ok, 1 hardware protect, 2 lock stuck, 3 protection stuck, 4 write error |

## Verification
The two stuck outcomes are the hardest to reach. They need a flash that takes a write but ignores part of it, which a passive responder never does.

The bench therefore runs a small status-register model behind the ports:

- While a lock bit is set, every other bit is read-only.
- Hardware-protect bits never change.
- An optional stuck set of bits refuses to clear.
- A chosen write attempt can be made to fail.

The bench sweeps every 8-bit initial status against five mask configurations. Each run takes one of these model variants and a varying acknowledge latency, so every exit of the sequence is reached many times.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

    localparam int SR_W  = 8;
    localparam int RES_W = 3;

    typedef logic [SR_W-1:0] sr_t;

    typedef struct packed {
        sr_t prot;
        sr_t lock;
        sr_t hwp;
        sr_t keep;
    } bpr_cfg_t;

    typedef enum logic [RES_W-1:0] {
        RES_OK         = 3'd0,
        RES_HW_PROT    = 3'd1,
        RES_LOCK_STUCK = 3'd2,
        RES_PROT_STUCK = 3'd3,
        RES_WR_FAIL    = 3'd4
    } bpr_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } bpr_state_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_LOCK,
        PH_FINAL
    } bpr_phase_e;

    // Status with the lock bits dropped, everything else untouched.
    function automatic sr_t lock_release_value(sr_t sr, bpr_cfg_t c);
        return sr & ~c.lock;
    endfunction

    // Final write: protection and lock cleared, limited to the keep set.
    function automatic sr_t unprotect_value(sr_t sr, bpr_cfg_t c);
        return sr & ~(c.prot | c.lock) & c.keep;
    endfunction

    // Hardware protect is active when a mask is given and all its bits read 0.
    function automatic logic hw_pin_blocks(sr_t sr, bpr_cfg_t c);
        return (c.hwp != '0) && ((sr & c.hwp) == '0);
    endfunction

endpackage

// File: rtl/bpr_cfg_latch.sv
module bpr_cfg_latch
    import bpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  bpr_cfg_t cfg_in,
    output bpr_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/bpr_status_eval.sv
module bpr_status_eval
    import bpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bpr_cfg_t cfg,
    input  logic     cap_status,
    input  sr_t      rd_data,
    input  logic     load_lock_wd,
    input  logic     load_final_wd,
    output logic     any_prot,
    output logic     any_lock,
    output logic     hw_blocked,
    output sr_t      wr_data
);

    sr_t status_q;
    sr_t wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (cap_status) begin
            status_q <= rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_q <= '0;
        end else if (load_lock_wd) begin
            wd_q <= lock_release_value(status_q, cfg);
        end else if (load_final_wd) begin
            wd_q <= unprotect_value(status_q, cfg);
        end
    end

    always_comb begin
        any_prot   = (status_q & cfg.prot) != '0;
        any_lock   = (status_q & cfg.lock) != '0;
        hw_blocked = hw_pin_blocks(status_q, cfg);
    end

    assign wr_data = wd_q;

    AST_LOCK_WD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        load_lock_wd |-> (any_lock && !hw_blocked)) else $error("lock write without lock"); // R5

    AST_WD_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load_lock_wd && load_final_wd)) else $error("two write values loaded"); // R7

endmodule

// File: rtl/bpr_fsm.sv
module bpr_fsm
    import bpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     rd_ack,
    input  logic     wr_ack,
    input  logic     wr_fail,
    input  logic     any_prot,
    input  logic     any_lock,
    input  logic     hw_blocked,
    output logic     cap_cfg,
    output logic     cap_status,
    output logic     load_lock_wd,
    output logic     load_final_wd,
    output logic     rd_req,
    output logic     wr_req,
    output logic     busy,
    output logic     done,
    output bpr_res_e result
);

    bpr_state_e state_q, state_d;
    bpr_phase_e phase_q, phase_d;
    bpr_res_e   result_q, result_d;
    logic       wr_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_FIRST;
            result_q <= RES_OK;
        end else begin
            state_q  <= state_d;
            phase_q  <= phase_d;
            result_q <= result_d;
        end
    end

    // Tracks whether a write completed in the current sequence.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen_q <= 1'b0;
        end else if (cap_cfg) begin
            wr_seen_q <= 1'b0;
        end else if (state_q == ST_WRITE && (wr_ack || wr_fail)) begin
            wr_seen_q <= 1'b1;
        end
    end

    always_comb begin
        state_d       = state_q;
        phase_d       = phase_q;
        result_d      = result_q;
        cap_cfg       = 1'b0;
        cap_status    = 1'b0;
        load_lock_wd  = 1'b0;
        load_final_wd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cap_cfg = 1'b1;
                    phase_d = PH_FIRST;
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (rd_ack) begin
                    cap_status = 1'b1;
                    state_d    = ST_EVAL;
                end
            end
            ST_EVAL: begin
                unique case (phase_q)
                    PH_FIRST: begin
                        if (!any_prot) begin
                            result_d = RES_OK;
                            state_d  = ST_DONE;
                        end else if (any_lock && hw_blocked) begin
                            result_d = RES_HW_PROT;
                            state_d  = ST_DONE;
                        end else if (any_lock) begin
                            load_lock_wd = 1'b1;
                            phase_d      = PH_LOCK;
                            state_d      = ST_WRITE;
                        end else begin
                            load_final_wd = 1'b1;
                            phase_d       = PH_FINAL;
                            state_d       = ST_WRITE;
                        end
                    end
                    PH_LOCK: begin
                        if (any_lock) begin
                            result_d = RES_LOCK_STUCK;
                            state_d  = ST_DONE;
                        end else begin
                            load_final_wd = 1'b1;
                            phase_d       = PH_FINAL;
                            state_d       = ST_WRITE;
                        end
                    end
                    default: begin
                        result_d = any_prot ? RES_PROT_STUCK : RES_OK;
                        state_d  = ST_DONE;
                    end
                endcase
            end
            ST_WRITE: begin
                if (wr_fail) begin
                    result_d = RES_WR_FAIL;
                    state_d  = ST_DONE;
                end else if (wr_ack) begin
                    state_d = ST_READ;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign rd_req = (state_q == ST_READ);
    assign wr_req = (state_q == ST_WRITE);
    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_DONE);
    assign result = result_q;

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req)) else $error("read and write requested together"); // R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> rd_req) else $error("read request dropped"); // R10

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack && !wr_fail) |=> wr_req) else $error("write request dropped"); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R10

    AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_fail) |=> (done && result == RES_WR_FAIL)) else $error("write error not reported"); // R9

    AST_HWP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done && result == RES_HW_PROT) |-> !wr_seen_q) else $error("write before hardware protect exit"); // R4

    AST_OK_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
        (done && result == RES_OK) |-> !any_prot) else $error("success with protection set"); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req && !wr_req && !done)) else $error("activity while idle"); // R2

endmodule

// File: rtl/flash_unprotect_ctrl.sv
module flash_unprotect_ctrl
    import bpr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SR_W-1:0]     prot_mask,
    input  logic [SR_W-1:0]     lock_mask,
    input  logic [SR_W-1:0]     hwp_mask,
    input  logic [SR_W-1:0]     keep_mask,
    output logic                sr_rd_req,
    input  logic                sr_rd_ack,
    input  logic [SR_W-1:0]     sr_rd_data,
    output logic                sr_wr_req,
    output logic [SR_W-1:0]     sr_wr_data,
    input  logic                sr_wr_ack,
    input  logic                sr_wr_fail,
    output logic                busy,
    output logic                done,
    output logic [RES_W-1:0]    result_code
);

    bpr_cfg_t cfg_in, cfg_q;
    logic     cap_cfg, cap_status, load_lock_wd, load_final_wd;
    logic     any_prot, any_lock, hw_blocked;
    bpr_res_e result;

    always_comb begin
        cfg_in.prot = prot_mask;
        cfg_in.lock = lock_mask;
        cfg_in.hwp  = hwp_mask;
        cfg_in.keep = keep_mask;
    end

    bpr_cfg_latch u_cfg (
        .clk     (clk),
        .rst     (rst),
        .capture (cap_cfg),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    bpr_status_eval u_eval (
        .clk           (clk),
        .rst           (rst),
        .cfg           (cfg_q),
        .cap_status    (cap_status),
        .rd_data       (sr_rd_data),
        .load_lock_wd  (load_lock_wd),
        .load_final_wd (load_final_wd),
        .any_prot      (any_prot),
        .any_lock      (any_lock),
        .hw_blocked    (hw_blocked),
        .wr_data       (sr_wr_data)
    );

    bpr_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .rd_ack        (sr_rd_ack),
        .wr_ack        (sr_wr_ack),
        .wr_fail       (sr_wr_fail),
        .any_prot      (any_prot),
        .any_lock      (any_lock),
        .hw_blocked    (hw_blocked),
        .cap_cfg       (cap_cfg),
        .cap_status    (cap_status),
        .load_lock_wd  (load_lock_wd),
        .load_final_wd (load_final_wd),
        .rd_req        (sr_rd_req),
        .wr_req        (sr_wr_req),
        .busy          (busy),
        .done          (done),
        .result        (result)
    );

    assign result_code = result;

    AST_START_READS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> sr_rd_req) else $error("start did not begin with a read"); // R2

endmodule

// File: tb/tb_flash_unprotect_ctrl.sv
module tb_flash_unprotect_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] prot_mask = '0, lock_mask = '0, hwp_mask = '0, keep_mask = '0;
    logic       sr_rd_req, sr_wr_req, busy, done;
    logic       sr_rd_ack = 1'b0, sr_wr_ack = 1'b0, sr_wr_fail = 1'b0;
    logic [7:0] sr_rd_data = '0, sr_wr_data;
    logic [2:0] result_code;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // flash status model state
    logic [7:0] m_sr = '0, m_stuck = '0;
    int         m_fail_at = 0, m_lat = 0;
    int         wr_cnt = 0;
    logic [7:0] first_wd = '0, last_wd = '0;

    always #10 clk = ~clk;

    flash_unprotect_ctrl dut (
        .clk(clk), .rst(rst), .start(start),
        .prot_mask(prot_mask), .lock_mask(lock_mask), .hwp_mask(hwp_mask), .keep_mask(keep_mask),
        .sr_rd_req(sr_rd_req), .sr_rd_ack(sr_rd_ack), .sr_rd_data(sr_rd_data),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .sr_wr_ack(sr_wr_ack), .sr_wr_fail(sr_wr_fail),
        .busy(busy), .done(done), .result_code(result_code)
    );

    // Model write: hardware-protect bits never change; while locked only lock bits change;
    // stuck bits never clear.
    function automatic logic [7:0] mdl_apply(logic [7:0] s, logic [7:0] wd, logic [7:0] lm,
                                             logic [7:0] hm, logic [7:0] st);
        logic [7:0] ro, n;
        ro = hm | (((s & lm) != 0) ? ~lm : 8'h00);
        n  = (wd & ~ro) | (s & ro);
        return n | (s & st);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Model responder
    initial begin
        int rc, wc;
        rc = 0; wc = 0;
        forever begin
            @(negedge clk);
            sr_rd_ack  = 1'b0;
            sr_wr_ack  = 1'b0;
            sr_wr_fail = 1'b0;
            sr_rd_data = m_sr;
            if (sr_rd_req) begin
                if (rc >= m_lat) begin sr_rd_ack = 1'b1; rc = 0; end
                else rc++;
            end else rc = 0;
            if (sr_wr_req) begin
                if (wc >= m_lat) begin
                    wc = 0;
                    wr_cnt++;
                    if (wr_cnt == 1) first_wd = sr_wr_data;
                    last_wd = sr_wr_data;
                    if (wr_cnt == m_fail_at) sr_wr_fail = 1'b1;
                    else begin
                        m_sr = mdl_apply(m_sr, sr_wr_data, lock_mask, hwp_mask, m_stuck);
                        sr_wr_ack = 1'b1;
                    end
                end else wc++;
            end else wc = 0;
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == 190000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    task automatic set_cfg(input int c);
        case (c)
            0: begin prot_mask = 8'h3C; lock_mask = 8'h00; hwp_mask = 8'h00; keep_mask = 8'hFF; end
            1: begin prot_mask = 8'h1C; lock_mask = 8'h80; hwp_mask = 8'h00; keep_mask = 8'hFF; end
            2: begin prot_mask = 8'h3C; lock_mask = 8'h80; hwp_mask = 8'h00; keep_mask = 8'hFF; end
            3: begin prot_mask = 8'h7C; lock_mask = 8'h80; hwp_mask = 8'h00; keep_mask = 8'hFF; end
            default: begin prot_mask = 8'h0C; lock_mask = 8'h80; hwp_mask = 8'h10; keep_mask = 8'h00; end
        endcase
    endtask

    task automatic run_case(input int c, input logic [7:0] init, input logic [7:0] stuck,
                            input int fail_at, input int lat, input logic dbl);
        logic [7:0] s, ef, el;
        int         ecode, ew, waited;
        logic       go;
        set_cfg(c);
        m_sr = init; m_stuck = stuck; m_fail_at = fail_at; m_lat = lat; wr_cnt = 0;
        // expected sequence from the requirements
        s = init; ew = 0; ecode = 0; ef = 0; el = 0; go = 1'b1;
        if ((s & prot_mask) == 0) begin
            go = 1'b0;                                         // R3
        end else if ((s & lock_mask) != 0) begin
            if (hwp_mask != 0 && (s & hwp_mask) == 0) begin    // R4 / R11
                ecode = 1; go = 1'b0;
            end else begin
                ew = 1; ef = s & ~lock_mask;                   // R5
                if (fail_at == 1) begin ecode = 4; go = 1'b0; end
                else begin
                    s = mdl_apply(s, ef, lock_mask, hwp_mask, stuck);
                    if ((s & lock_mask) != 0) begin ecode = 2; go = 1'b0; end   // R6
                end
            end
        end
        if (go) begin
            ew++;
            el = s & ~(prot_mask | lock_mask) & keep_mask;     // R7
            if (ew == 1) ef = el;
            if (fail_at == ew) ecode = 4;                      // R9
            else begin
                s = mdl_apply(s, el, lock_mask, hwp_mask, stuck);
                ecode = ((s & prot_mask) != 0) ? 3 : 0;        // R8
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (dbl) begin
            @(negedge clk); start = 1'b1;                      // R2: ignored while busy
            @(negedge clk); start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 300) begin @(negedge clk); waited++; end
        chk(done, "R10 done seen", done, 1);
        chk(result_code == ecode[2:0], "R3/R4/R6/R8/R9 result", result_code, ecode);
        chk(wr_cnt == ew, "R3/R4/R6 write count", wr_cnt, ew);
        chk(m_sr == s, "R8 final status", m_sr, s);
        if (ew >= 1) chk(first_wd == ef, "R5 first write value", first_wd, ef);
        if (ew == 2 || (ew == 1 && ef == el)) chk(last_wd == el, "R7 final write value", last_wd, el);
        @(negedge clk);
        chk(!done, "R10 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(!sr_rd_req && !busy, "R2 no restart after done", {sr_rd_req, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy,           "R1 busy",   busy, 0);
        chk(!done,           "R1 done",   done, 0);
        chk(!sr_rd_req,      "R1 rd_req", sr_rd_req, 0);
        chk(!sr_wr_req,      "R1 wr_req", sr_wr_req, 0);
        chk(result_code == 0, "R1 result", result_code, 0);
        for (int c = 0; c < 5; c++) begin
            for (int i = 0; i < 256; i++) begin
                logic [7:0] pm, stuck;
                int v, fa;
                set_cfg(c);
                pm = prot_mask;
                v = (i ^ (c * 3)) % 6;
                stuck = 8'h00; fa = 0;
                case (v)
                    3: stuck = lock_mask;            // lock refuses to clear: R6
                    4: stuck = pm & (~pm + 8'h01);   // lowest protection bit stuck: R8
                    5: fa = ((i >> 2) % 2) + 1;      // write port error: R9
                    default: ;
                endcase
                run_case(c, i[7:0], stuck, fa, i % 3, (i % 7) == 0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule